// File: doc/BRIEF.md
# Depth-16 Frame Time Interleaver

This block spreads each frame of coded bits across sixteen consecutive output frames, so that a burst of channel errors lands on many different frames after de-interleaving. Bytes of a frame arrive on a byte port, opened by a frame-start flag. Each accepted byte is stored in the slot of the current frame. Sixteen slots of `FRAME_BYTES` bytes each are used in rotation, and every slot begins at its own base address, `slot * FRAME_BYTES`.

For every accepted input byte, the block returns one output byte at the same byte position of the output frame. Each of the eight output bits comes from an earlier frame. The lag, in frames, depends only on the bit index modulo 16. The current frame's own bits come straight from the incoming byte. For that reason the slot being overwritten, which holds a frame sixteen frames old, is never needed again. Positions that would refer to frames received before the first frame after reset return zero.

Top module: `ti16_frame_interleaver`

## Requirements
- R1: A frame opens when `in_valid` and `in_sof` are both high, and that byte is byte 0. A byte with `in_valid` high while no frame is open is ignored and produces no output byte. A cycle with `in_valid` low is also ignored, including its `in_byte`.
- R2: On the clock edge that accepts a byte, `out_valid` rises for one cycle. On the same edge `out_sof` rises if that byte was byte 0 of its frame.
- R3: A frame closes after `FRAME_BYTES` accepted bytes. The next frame is written to the next of the 16 slots in rotation, wrapping from 15 to 0.
- R4: Let bit i of a frame be bit 7-(i mod 8) of byte floor(i/8), so bytes are MSB first. Output bit i of output frame r equals input bit i of input frame r-L, where L = 15 - rev4(i mod 16). Here rev4 reverses the order of the four bits.
- R5: Bits with i mod 16 = 15 have L = 0 and are copied from the incoming byte itself.
- R6: When r-L is negative, meaning the frame comes before the first frame after reset, the output bit is 0.
- R7: A byte with `in_sof` high while a frame is still open restarts that frame at byte 0 in the same slot. The frame count does not advance.
- R8: While reset is held, `out_valid`, `out_sof` and `out_byte` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | Marks byte 0 of an input frame |
| in_byte | input | 8 | Coded input byte, first bit in bit 7 |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | Marks byte 0 of an output frame |
| out_byte | output | 8 | Interleaved output byte, first bit in bit 7 |

## Verification
A wrong slot pointer or frame count shows on the very next output byte. For most bit positions, the wrong earlier frame is read or zero is substituted. The reference model therefore compares every output byte in every cycle against frames kept in its own history. A fault that touches only the zero-lag bit, or only the zero-fill window, shows within the first frame that exercises that position. Running more than sixteen frames brings out any fault in the slot wrap or in the saturation of the fill count. The frame restart and the bytes sent outside a frame check that ignored input leaves no trace on the port.

// File: rtl/ti16_pkg.sv
package ti16_pkg;
  localparam int SLOTS = 16;
  localparam int SLOT_W = 4;

  // lag in frames for a bit whose index modulo 16 is m
  function automatic logic [SLOT_W-1:0] frame_lag(input logic [SLOT_W-1:0] m);
    logic [SLOT_W-1:0] rev;
    rev = {m[0], m[1], m[2], m[3]};
    return 4'd15 - rev;
  endfunction
endpackage

// File: rtl/ti16_wr_ctrl.sv
module ti16_wr_ctrl #(
  parameter int FRAME_BYTES = 8,
  localparam int PW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          accept,
  output logic [PW-1:0] pos,
  output logic [3:0]    slot,
  output logic [3:0]    fill
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_BYTES - 1);

  logic          open_q, open_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [3:0]    slot_q, slot_d;
  logic [3:0]    fill_q, fill_d;
  logic          last;

  always_comb begin
    pos    = in_sof ? '0 : pos_q;
    accept = in_valid & (in_sof | open_q);
    last   = (pos == LAST);
    open_d = open_q;
    pos_d  = pos_q;
    slot_d = slot_q;
    fill_d = fill_q;
    if (accept) begin
      open_d = !last;
      pos_d  = last ? '0 : pos + PW'(1);
      if (last) begin
        slot_d = slot_q + 4'd1;
        if (fill_q != 4'hF) fill_d = fill_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pos_q  <= '0;
      slot_q <= '0;
      fill_q <= '0;
    end else if (accept) begin
      open_q <= open_d;
      pos_q  <= pos_d;
      slot_q <= slot_d;
      fill_q <= fill_d;
    end
  end

  assign slot = slot_q;
  assign fill = fill_q;
endmodule

// File: rtl/ti16_store.sv
module ti16_store #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      waddr,
  input  logic [7:0]         wdata,
  input  logic [7:0][AW-1:0] raddr,
  output logic [7:0]         rbit
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // port k delivers the bit that sits at output position 7-k
  for (genvar k = 0; k < 8; k++) begin : g_rd
    assign rbit[k] = mem[raddr[k]][7-k];
  end
endmodule

// File: rtl/ti16_gather.sv
module ti16_gather
  import ti16_pkg::*;
#(
  parameter int FRAME_BYTES = 8,
  localparam int PW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
  localparam int AW = $clog2(SLOTS * FRAME_BYTES)
) (
  input  logic [PW-1:0]      pos,
  input  logic [3:0]         slot,
  input  logic [3:0]         fill,
  input  logic [7:0]         in_byte,
  input  logic [7:0]         rbit,
  output logic [7:0][AW-1:0] raddr,
  output logic [7:0]         gbyte
);
  localparam logic [AW-1:0] FB_W = AW'(FRAME_BYTES);

  for (genvar k = 0; k < 8; k++) begin : g_bit
    localparam logic [2:0] K3 = 3'(k);
    logic [3:0] lag;
    logic [3:0] src;
    assign lag      = frame_lag({pos[0], K3});
    assign src      = slot - lag;
    assign raddr[k] = AW'(src) * FB_W + AW'(pos);
    assign gbyte[7-k] = (lag == 4'd0) ? in_byte[7-k]
                      : ((lag <= fill) ? rbit[k] : 1'b0);
  end
endmodule

// File: rtl/ti16_frame_interleaver.sv
module ti16_frame_interleaver
  import ti16_pkg::*;
#(
  parameter int FRAME_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_byte,
  output logic       out_valid,
  output logic       out_sof,
  output logic [7:0] out_byte
);
  localparam int PW    = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;
  localparam int DEPTH = SLOTS * FRAME_BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam logic [AW-1:0] FB_W = AW'(FRAME_BYTES);

  logic [1:0]         sync_q;
  logic               srst_n;
  logic               accept;
  logic [PW-1:0]      wr_pos;
  logic [3:0]         wr_slot;
  logic [3:0]         fill;
  logic [AW-1:0]      waddr;
  logic [7:0][AW-1:0] raddr;
  logic [7:0]         rbit;
  logic [7:0]         gbyte;
  logic               valid_d, sof_d;
  logic [7:0]         byte_d;
  logic               valid_q, sof_q;
  logic [7:0]         byte_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign srst_n = sync_q[1];

  ti16_wr_ctrl #(.FRAME_BYTES(FRAME_BYTES)) ctrl_i (
    .clk(clk), .rst_n(srst_n), .in_valid(in_valid), .in_sof(in_sof),
    .accept(accept), .pos(wr_pos), .slot(wr_slot), .fill(fill)
  );

  assign waddr = AW'(wr_slot) * FB_W + AW'(wr_pos);

  ti16_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .we(accept), .waddr(waddr), .wdata(in_byte),
    .raddr(raddr), .rbit(rbit)
  );

  ti16_gather #(.FRAME_BYTES(FRAME_BYTES)) gather_i (
    .pos(wr_pos), .slot(wr_slot), .fill(fill), .in_byte(in_byte),
    .rbit(rbit), .raddr(raddr), .gbyte(gbyte)
  );

  always_comb begin
    valid_d = accept;
    sof_d   = accept & in_sof;
    byte_d  = accept ? gbyte : byte_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
      byte_q  <= '0;
    end else begin
      valid_q <= valid_d;
      sof_q   <= sof_d;
      byte_q  <= byte_d;
    end
  end

  assign out_valid = valid_q;
  assign out_sof   = sof_q;
  assign out_byte  = byte_q;
endmodule

// File: rtl/ti16_chk.sv
module ti16_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_sof,
  input logic       in_lsb,
  input logic       out_valid,
  input logic       out_sof,
  input logic       out_lsb,
  input logic [3:0] wr_slot,
  input logic [3:0] fill
);
  logic [15:0] opos_q;
  logic [15:0] opos_cur;

  assign opos_cur = out_sof ? 16'd0 : opos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         opos_q <= '0;
    else if (out_valid) opos_q <= opos_cur + 16'd1;
  end

  // R2
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  // R1
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R2
  sof_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> $past(in_sof));

  // R5
  nolag_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && opos_cur[0]) |-> (out_lsb == $past(in_lsb)));

  // R3
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot != $past(wr_slot)) |-> (wr_slot == $past(wr_slot) + 4'd1));

  // R6
  fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill >= $past(fill));

  // R3
  slot_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill != 4'hF) |-> (wr_slot == fill));
endmodule

bind ti16_frame_interleaver ti16_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
  .in_lsb(in_byte[0]), .out_valid(out_valid), .out_sof(out_sof),
  .out_lsb(out_byte[0]), .wr_slot(wr_slot), .fill(fill)
);

// File: tb/ti16_frame_interleaver_tb_top.sv
module ti16_frame_interleaver_tb_top;
  localparam int FB = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, in_valid, in_sof;
  logic [7:0] in_byte;
  wire        out_valid, out_sof;
  wire  [7:0] out_byte;

  ti16_frame_interleaver #(.FRAME_BYTES(FB)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .out_valid(out_valid), .out_sof(out_sof),
    .out_byte(out_byte)
  );

  int    total = 0;
  int    bad   = 0;
  string req   = "R8";

  logic [7:0] fm [0:63][0:FB-1];
  int   r      = 0;
  int   mpos   = 0;
  bit   mframe = 0;
  bit   exp_v  = 0;
  bit   exp_s  = 0;
  logic [7:0] exp_b = 8'h00;

  function automatic int rev4(input int m);
    int x = 0;
    for (int j = 0; j < 4; j++) if (m[j]) x |= (1 << (3 - j));
    return x;
  endfunction

  task automatic check_out();
    total++;
    if (out_valid !== exp_v) begin
      bad++;
      $display("FAIL %s out_valid=%0b expected %0b", req, out_valid, exp_v);
    end else if (exp_v && (out_sof !== exp_s || out_byte !== exp_b)) begin
      bad++;
      $display("FAIL %s sof/byte=%0b/%02h expected %0b/%02h",
               req, out_sof, out_byte, exp_s, exp_b);
    end
  endtask

  task automatic step(input bit v, input bit s, input logic [7:0] b);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_sof   = s;
    in_byte  = b;
    if (v && (s || mframe)) begin
      int p = s ? 0 : mpos;
      logic [7:0] e = 8'h00;
      for (int k = 0; k < 8; k++) begin
        int i   = 8 * p + k;
        int lag = 15 - rev4(i % 16);
        bit bv;
        if (lag == 0)      bv = b[7-k];
        else if (r < lag)  bv = 1'b0;
        else               bv = fm[r-lag][p][7-k];
        e[7-k] = bv;
      end
      fm[r][p] = b;
      exp_v = 1'b1;
      exp_s = s;
      exp_b = e;
      if (p == FB - 1) begin
        r++;
        mframe = 0;
        mpos   = 0;
      end else begin
        mframe = 1;
        mpos   = p + 1;
      end
    end else begin
      exp_v = 1'b0;
      exp_s = 1'b0;
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int p);
    return 8'((f * 53 + p * 29 + 7) ^ (f << 3));
  endfunction

  task automatic send_frame(input int f, input bit gaps);
    for (int p = 0; p < FB; p++) begin
      if (gaps && (p % 3 == 1)) step(1'b0, 1'b0, 8'h5A);
      step(1'b1, p == 0, pat(f, p));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    bad++;
    $display("timeout: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_byte = 8'h00;
    repeat (3) @(negedge clk);
    // R8 reset state
    total++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_byte !== 8'h00) begin
      bad++;
      $display("FAIL R8 out=%0b/%0b/%02h expected 0/0/00", out_valid, out_sof, out_byte);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 8'h00);

    req = "R1"; // bytes outside any frame
    repeat (3) step(1'b1, 1'b0, 8'hAA);

    req = "R6"; // zero fill while history is short
    for (int f = 0; f < 15; f++) send_frame(f, f % 4 == 2);

    req = "R7"; // restart of an open frame
    step(1'b1, 1'b1, 8'hC3);
    step(1'b1, 1'b0, 8'h3C);
    step(1'b1, 1'b0, 8'hF0);
    send_frame(15, 1'b0);

    req = "R3"; // slot rotation and wrap
    for (int f = 16; f < 32; f++) send_frame(f, 1'b0);

    req = "R1";
    repeat (2) step(1'b1, 1'b0, 8'h77);

    req = "R5"; // extreme patterns expose the zero-lag bit
    for (int f = 32; f < 40; f++)
      for (int p = 0; p < FB; p++)
        step(1'b1, p == 0, (f % 2 == 0) ? 8'hFF : 8'h00);

    req = "R4";
    for (int f = 40; f < 48; f++) send_frame(f, 1'b0);

    req = "R2"; // gaps inside frames
    for (int f = 48; f < 56; f++) send_frame(f, 1'b1);

    repeat (3) step(1'b0, 1'b0, 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule